// File: doc/BRIEF.md
# Fast Ethernet Transmit Symbol Encoder

This block turns the nibble stream of a 100 Mb/s MAC into the serial line-symbol stream of the physical layer, one code bit per clock of a 125 MHz symbol clock. Each accepted nibble becomes a 5-bit code group. The encoder also supplies the framing groups itself: idle between frames, a start delimiter pair when transmit enable rises, an end delimiter pair when it falls, and an error group on request. The code bits then pass through the line coding chain, and the result is a two-bit signed level code.

The MAC side is paced by the encoder. The `nib_take` output is high for one clock in every five, and the transmit inputs are sampled at the rising edge that ends that clock. The `fiber_mode` input selects between two chains. In copper mode the code bits are scrambled, converted to NRZI and then encoded as three-level MLT3. In fiber mode the scrambler and the MLT3 stage are skipped, so the output carries the two-level NRZI of the unscrambled code bits.

Top module: `fe_tx_encoder`

## Requirements
- R1: While the encoder is between frames and `tx_en` is low at a sampling edge, the idle group 11111 is sent.
- R2: When `tx_en` is high at the first sampling edge of a frame, the group J (11000) is sent, and K (10001) follows at the next sampling edge. The nibbles offered at those two edges are not sent.
- R3: At a sampling edge inside a frame with `tx_en` high and `tx_er` low, `txd` is mapped as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R4: At a sampling edge inside a frame with both `tx_en` and `tx_er` high, the group H (00100) is sent in place of the data group.
- R5: The first sampling edge inside a frame that finds `tx_en` low sends T (01101). The next sampling edge sends R (00111) whatever the inputs are. The encoder is then between frames again.
- R6: `nib_take` is high in exactly one clock of every five. It is high in the first clock after reset. Every group is sent one bit per clock, leftmost bit first, in the five clocks after the edge that sampled it.
- R7: In copper mode each code bit is XORed with a key bit from an 11-bit register s. The register resets to 11'h7FF. On every clock the key is s[10]^s[8], and s shifts left with the key entering at bit 0 (x^11+x^9+1). The keystream repeats every 2047 bits.
- R8: The NRZI stage toggles its state on a 1 bit and holds it on a 0 bit. The output reflects each bit at the edge that consumes it.
- R9: In copper mode the level steps through the cycle 0, +1, 0, −1 on each 1 bit and holds on a 0 bit.
- R10: In fiber mode no scrambling is applied, and the level is +1 when the NRZI state is 1 and 0 when it is 0.
- R11: During and after reset, and before any bit is consumed, the level is 0, the NRZI state is 0 and the MLT3 cycle is at its first 0.
- R12: `line_lvl` is encoded as 2'b01 for +1, 2'b00 for 0 and 2'b11 for −1. The value 2'b10 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fiber_mode | input | 1 | 1 selects fiber (no scrambler, no MLT3), 0 selects copper |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_er | input | 1 | Transmit error from the MAC |
| txd | input | 4 | Transmit data nibble |
| nib_take | output | 1 | High in the clock whose closing edge samples the MAC inputs |
| line_lvl | output | 2 | Signed line level: 01 = +1, 00 = 0, 11 = −1 |

## Verification
All sixteen data nibbles are sent in one frame, in both modes. A data table error would corrupt only those groups, while a scrambler or line-stage error would show up in idle as well. Frames with `tx_er` held high, a one-nibble frame and back-to-back frames with `tx_en` high during the R slot check the delimiters and show that the R slot ignores its inputs. A long idle run in copper mode is decoded from the level changes alone. It recovers the keystream and checks its 2047-bit repetition without any knowledge of the register inside.

// File: rtl/fe_tx_pkg.sv
package fe_tx_pkg;
    localparam int GRP_W  = 5;
    localparam int NIB_W  = 4;
    localparam int LFSR_W = 11;
    localparam int CNT_W  = $clog2(GRP_W);
    localparam int TAP_HI = LFSR_W - 1;
    localparam int TAP_LO = 8;

    typedef logic [GRP_W-1:0] grp_t;
    typedef logic [1:0]       lvl_t;

    localparam lvl_t LVL_POS  = 2'b01;
    localparam lvl_t LVL_ZERO = 2'b00;
    localparam lvl_t LVL_NEG  = 2'b11;

    localparam grp_t CG_IDLE = 5'b11111;
    localparam grp_t CG_J    = 5'b11000;
    localparam grp_t CG_K    = 5'b10001;
    localparam grp_t CG_T    = 5'b01101;
    localparam grp_t CG_R    = 5'b00111;
    localparam grp_t CG_H    = 5'b00100;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SSD2 = 2'd1,
        ST_DATA = 2'd2,
        ST_ESD2 = 2'd3
    } enc_state_e;

    typedef struct packed {
        enc_state_e       st;
        logic [CNT_W-1:0] cnt;
        grp_t             sh;
    } grp_regs_t;

    typedef struct packed {
        logic       nrzi;
        logic [1:0] ph;
    } line_regs_t;

    function automatic grp_t map_nibble(input logic [NIB_W-1:0] n);
        grp_t g;
        case (n)
            4'h0: g = 5'b11110;
            4'h1: g = 5'b01001;
            4'h2: g = 5'b10100;
            4'h3: g = 5'b10101;
            4'h4: g = 5'b01010;
            4'h5: g = 5'b01011;
            4'h6: g = 5'b01110;
            4'h7: g = 5'b01111;
            4'h8: g = 5'b10010;
            4'h9: g = 5'b10011;
            4'hA: g = 5'b10110;
            4'hB: g = 5'b10111;
            4'hC: g = 5'b11010;
            4'hD: g = 5'b11011;
            4'hE: g = 5'b11100;
            default: g = 5'b11101;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/fe_tx_grouper.sv
module fe_tx_grouper
    import fe_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] txd,
    output logic             nib_take,
    output logic             code_bit
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GRP_W - 1);

    grp_regs_t r_q, r_d;

    always_comb begin
        grp_t       grp;
        enc_state_e nxt;
        r_d      = r_q;
        nib_take = (r_q.cnt == LAST);
        grp      = CG_IDLE;
        nxt      = r_q.st;
        case (r_q.st)
            ST_IDLE: begin
                if (tx_en) begin
                    grp = CG_J;
                    nxt = ST_SSD2;
                end
            end
            ST_SSD2: begin
                grp = CG_K;
                nxt = ST_DATA;
            end
            ST_DATA: begin
                if (tx_en) begin
                    grp = tx_er ? CG_H : map_nibble(txd);
                end else begin
                    grp = CG_T;
                    nxt = ST_ESD2;
                end
            end
            default: begin
                grp = CG_R;
                nxt = ST_IDLE;
            end
        endcase
        if (nib_take) begin
            r_d.sh  = grp;
            r_d.cnt = '0;
            r_d.st  = nxt;
        end else begin
            r_d.sh  = {r_q.sh[GRP_W-2:0], 1'b0};
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.cnt <= LAST;
            r_q.sh  <= CG_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign code_bit = r_q.sh[GRP_W-1];
endmodule

// File: rtl/fe_tx_scrambler.sv
module fe_tx_scrambler
    import fe_tx_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    output logic              bit_out,
    output logic [LFSR_W-1:0] state
);
    logic [LFSR_W-1:0] lfsr_q, lfsr_d;
    logic              key;

    always_comb begin
        key     = lfsr_q[TAP_HI] ^ lfsr_q[TAP_LO];
        lfsr_d  = {lfsr_q[LFSR_W-2:0], key};
        bit_out = bit_in ^ key;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign state = lfsr_q;
endmodule

// File: rtl/fe_tx_line.sv
module fe_tx_line
    import fe_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fiber_mode,
    input  logic bit_in,
    output lvl_t level
);
    line_regs_t l_q, l_d;

    always_comb begin
        l_d      = l_q;
        l_d.nrzi = l_q.nrzi ^ bit_in;
        if (bit_in) l_d.ph = l_q.ph + 2'd1;
        if (fiber_mode) begin
            level = l_q.nrzi ? LVL_POS : LVL_ZERO;
        end else begin
            case (l_q.ph)
                2'd1:    level = LVL_POS;
                2'd3:    level = LVL_NEG;
                default: level = LVL_ZERO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end
endmodule

// File: rtl/fe_tx_encoder.sv
module fe_tx_encoder
    import fe_tx_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SCR_SEED = 11'h7FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fiber_mode,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] txd,
    output logic             nib_take,
    output logic [1:0]       line_lvl
);
    logic              code_bit;
    logic              scr_bit;
    logic              line_bit;
    logic [LFSR_W-1:0] scr_state;

    fe_tx_grouper u_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .tx_er    (tx_er),
        .txd      (txd),
        .nib_take (nib_take),
        .code_bit (code_bit)
    );

    fe_tx_scrambler #(.SEED(SCR_SEED)) u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (code_bit),
        .bit_out (scr_bit),
        .state   (scr_state)
    );

    assign line_bit = fiber_mode ? code_bit : scr_bit;

    fe_tx_line u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .fiber_mode (fiber_mode),
        .bit_in     (line_bit),
        .level      (line_lvl)
    );
endmodule

// File: rtl/fe_tx_encoder_chk.sv
module fe_tx_encoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fiber_mode,
    input logic        nib_take,
    input logic [1:0]  line_lvl,
    input logic [10:0] scr_state
);
    p_take_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nib_take |=> !nib_take);

    p_lvl_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        line_lvl != 2'b10);

    p_fiber_unipolar_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fiber_mode |-> line_lvl != 2'b11);

    p_mlt3_no_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fiber_mode && !$past(fiber_mode)) |->
            !((line_lvl == 2'b01 && $past(line_lvl) == 2'b11) ||
              (line_lvl == 2'b11 && $past(line_lvl) == 2'b01)));

    p_lfsr_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scr_state != 11'd0);
endmodule

bind fe_tx_encoder fe_tx_encoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fiber_mode (fiber_mode),
    .nib_take   (nib_take),
    .line_lvl   (line_lvl),
    .scr_state  (scr_state)
);

// File: tb/test_fe_tx_encoder.sv
module test_fe_tx_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fiber_mode = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       nib_take;
    logic [1:0] line_lvl;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    fe_tx_encoder i_fe_tx_encoder (
        .clk(clk), .rst_n(rst_n), .fiber_mode(fiber_mode), .tx_en(tx_en),
        .tx_er(tx_er), .txd(txd), .nib_take(nib_take), .line_lvl(line_lvl)
    );

    always #5 clk = ~clk;

    // independent reference built from the requirements
    logic [4:0]  m_sh;
    int          m_cnt;
    int          m_st;      // 0 idle, 1 after J, 2 data, 3 after T
    logic [10:0] m_lf;
    logic        m_nrzi;
    int          m_ph;
    string       m_bittag, m_outtag;

    function automatic logic [4:0] tbl(input logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    function automatic logic [1:0] exp_lvl();
        if (fiber_mode) return m_nrzi ? 2'b01 : 2'b00;
        case (m_ph)
            1: return 2'b01;
            3: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    always @(posedge clk) begin
        logic b, key, cb;
        logic [4:0] g;
        string tg;
        if (!rst_n) begin
            m_sh = 5'b11111; m_cnt = 4; m_st = 0; m_lf = 11'h7FF;
            m_nrzi = 1'b0; m_ph = 0; m_bittag = "R1"; m_outtag = "R11";
        end else begin
            b   = m_sh[4];
            key = m_lf[10] ^ m_lf[8];
            cb  = fiber_mode ? b : (b ^ key);
            m_lf = {m_lf[9:0], key};
            m_nrzi = m_nrzi ^ cb;
            if (cb) m_ph = (m_ph + 1) % 4;
            m_outtag = m_bittag;
            if (m_cnt == 4) begin
                g = 5'b11111; tg = "R1";
                case (m_st)
                    0: if (tx_en) begin g = 5'b11000; tg = "R2"; m_st = 1; end
                    1: begin g = 5'b10001; tg = "R2"; m_st = 2; end
                    2: if (tx_en) begin
                           if (tx_er) begin g = 5'b00100; tg = "R4"; end
                           else begin g = tbl(txd); tg = "R3"; end
                       end else begin g = 5'b01101; tg = "R5"; m_st = 3; end
                    default: begin g = 5'b00111; tg = "R5"; m_st = 0; end
                endcase
                m_sh = g; m_cnt = 0; m_bittag = tg;
            end else begin
                m_sh = {m_sh[3:0], 1'b0};
                m_cnt = m_cnt + 1;
            end
        end
    end

    // lockstep comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (nib_take !== (m_cnt == 4)) begin
                errors++;
                $display("FAIL R6 nib_take actual=%0b expected=%0b", nib_take, m_cnt == 4);
            end
            checks++;
            if (line_lvl !== exp_lvl()) begin
                errors++;
                $display("FAIL %s %s line_lvl actual=%b expected=%b", m_outtag,
                         fiber_mode ? "R10 R8" : "R7 R8 R9", line_lvl, exp_lvl());
            end
            checks++;
            if (line_lvl === 2'b10) begin
                errors++;
                $display("FAIL R12 illegal level actual=%b expected=not 10", line_lvl);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL R6 watchdog actual=%0d cycles expected=completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic put(input logic en, input logic er, input logic [3:0] d);
        while (!nib_take) @(negedge clk);
        tx_en = en; tx_er = er; txd = d;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic fib);
        @(negedge clk);
        rst_n = 1'b0; fiber_mode = fib; tx_en = 0; tx_er = 0; txd = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (line_lvl !== 2'b00 || nib_take !== 1'b1) begin
            errors++;
            $display("FAIL R11 reset lvl=%b take=%b expected lvl=00 take=1", line_lvl, nib_take);
        end
        rst_n = 1'b1;
    endtask

    task automatic traffic();
        for (int i = 0; i < 6; i++) put(0, 0, 4'h5);            // R1 idle
        put(1, 0, 4'h5); put(1, 0, 4'h5);                      // R2 J K
        for (int i = 0; i < 16; i++) put(1, 0, 4'(i));          // R3 table
        put(1, 1, 4'h3);                                       // R4 error
        put(1, 0, 4'hA);
        put(0, 0, 4'h0); put(0, 1, 4'hF);                      // R5 T R
        for (int i = 0; i < 3; i++) put(0, 0, 4'h0);
        for (int i = 0; i < 5; i++) put(1, 1, 4'(i));           // R4 whole frame
        put(0, 0, 4'h0);
        put(1, 0, 4'h7);                                       // R5: high in R slot ignored
        put(1, 0, 4'h9); put(1, 0, 4'h1); put(1, 0, 4'hC);
        put(0, 0, 4'h0); put(0, 0, 4'h0);
        put(1, 0, 4'h2);                                       // R2 one-nibble frame
        for (int i = 0; i < 6; i++) put(0, 0, 4'h0);
    endtask

    logic ks [4200];

    initial begin
        logic [1:0] prev;
        int mism;
        do_reset(1'b0);
        // R7: recover keystream from level changes during idle (all-ones code)
        prev = 2'b00;
        for (int i = 0; i < 4200; i++) begin
            @(negedge clk);
            ks[i] = (line_lvl != prev) ^ 1'b1;
            prev = line_lvl;
        end
        mism = 0;
        for (int i = 0; i < 2100; i++) if (ks[i] != ks[i + 2047]) mism++;
        checks++;
        if (mism != 0) begin
            errors++;
            $display("FAIL R7 keystream period mismatches actual=%0d expected=0", mism);
        end
        traffic();
        do_reset(1'b1);
        traffic();
        repeat (10) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule